// File: doc/BRIEF.md
# Mode-Filtered Performance Counter Bank

This block is a bank of programmable event counters for one processor hart. Each counter slot holds a 64-bit count, seen by software as a low and a high 32-bit half. It also holds a control word with five per-mode inhibit bits and a sticky overflow flag. Each slot has one event strobe. On a strobe the slot counts only if three things hold: the index is implemented, its bit in a shared count-inhibit register is clear, and the inhibit bit for the current privilege level and virtualization state is clear. A count at all-ones wraps to zero. That wrap drives a small per-slot overflow state machine, and the machine produces a local overflow interrupt request.

The overflow state machine has three states:

| State | Overflow flag | Interrupt request |
|---|---|---|
| OVF_CLEAR | clear | none |
| OVF_PENDING | set | raised |
| OVF_ACKED | set | already acknowledged |

Its transitions are:

- T_WRAP_NEW: OVF_CLEAR to OVF_PENDING on a wrap.
- T_SET_QUIET: OVF_CLEAR to OVF_ACKED when software writes the flag as one.
- T_ACK: OVF_PENDING to OVF_ACKED on an acknowledge pulse that names the slot.
- T_SW_CLEAR: OVF_PENDING or OVF_ACKED to OVF_CLEAR when software writes the flag as zero.

A wrap seen in OVF_PENDING or OVF_ACKED leaves the state unchanged. The interrupt output is the OR of all slots in OVF_PENDING.

Software reaches the bank through a CSR-style port. Writes are synchronous and reads are combinational. Event selection and trap delivery sit outside the block.

Top module: `pmc_bank`

## Requirements
- R1: A slot counts an event only when its index bit is set in the AVAIL_MASK parameter and its bit in the shared count-inhibit register is clear.
- R2: The mode filter is selected by the `priv` input:
  - U (2'b00): the u bit applies when `virt` is 0, the vu bit when `virt` is 1.
  - S (2'b01): the s bit applies when `virt` is 0, the vs bit when `virt` is 1.
  - Encoding 2'b10: counting is always suppressed.
  - A write to a control word or to the inhibit register governs counting from the next cycle.
- R3: In machine mode (priv 2'b11) only the m bit applies, whatever `virt` is.
- R4: An event at an all-ones count wraps the count to zero. It does not saturate.
- R5: A wrap in OVF_CLEAR sets the flag and raises the slot's interrupt request. A wrap with the flag already set raises no new request.
- R6: The high half increments only on a counted event that finds the low half at all-ones.
- R7: The control word reads with the flag at bit 31 and inhibits m, s, u, vs, vu at bits 30, 29, 28, 27, 26. All other bits read zero.
- R8: Indices 0 to 2 are reserved for fixed counters. They never count and read zero even when set in AVAIL_MASK, and unimplemented indices behave the same way.
- R9: A write to a count half takes effect at the next clock edge. Any event for that slot in the same cycle is dropped.
- R10: The flag clears only on a software write of zero to bit 31. `ovf_ack` with `ovf_ack_idx` moves a pending slot to OVF_ACKED. `ovf_irq` is high while any slot is in OVF_PENDING.
- R11: When a wrap and a control-word write to the same slot fall in one cycle, the wrap decides the flag and the written flag bit is discarded.
- R12: Reset clears every count, every control word and the inhibit register, and leaves `ovf_irq` low.
- R13: The address is {sel[2:0], index[4:0]}:
  - sel 0: count low half.
  - sel 1: count high half.
  - sel 2: control word.
  - sel 3: inhibit register (the index is ignored).
  - sel 4 to 7: read zero and are ignored on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 8 | {sel, index} register address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | Combinational CSR read data |
| evt_strobe | input | 32 | One event pulse per counter index |
| priv | input | 2 | Current privilege level |
| virt | input | 1 | Virtualization active |
| ovf_ack | input | 1 | Overflow acknowledge pulse |
| ovf_ack_idx | input | 5 | Index being acknowledged |
| ovf_irq | output | 1 | Local overflow interrupt request |

## Verification
Two functions can meet in one cycle. A counter can wrap in the same cycle that software writes its control word. An event can also arrive in the same cycle as a write to its count half. The bench provokes both on purpose:

- It preloads a slot to all-ones, then strobes the slot while writing its control word with the flag bit zero.
- It strobes a slot while writing its count low half.

For the first case it then expects OVF_PENDING and a raised interrupt. For the second it expects the written value with no increment. Random traffic aims count writes near all-ones, so both collisions, and acknowledges colliding with wraps, recur. Each is judged against a bench model built from the requirements.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int HALF_W  = 32;
    localparam int CNT_W   = 2 * HALF_W;
    localparam int OF_BIT  = 31;
    localparam int INH_LSB = 26;
    localparam int FIXED_N = 3;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_t;

    typedef enum logic [1:0] {
        OVF_CLEAR   = 2'd0,
        OVF_PENDING = 2'd1,
        OVF_ACKED   = 2'd2
    } ovf_state_t;

    typedef enum logic [2:0] {
        SEL_CNT_LO = 3'd0,
        SEL_CNT_HI = 3'd1,
        SEL_CTL    = 3'd2,
        SEL_GINH   = 3'd3
    } csr_sel_t;

    // order matches control bits 30..26
    typedef struct packed {
        logic m;
        logic s;
        logic u;
        logic vs;
        logic vu;
    } inh_t;

    function automatic logic [HALF_W-1:0] ctl_pack(input logic flag, input inh_t inh);
        logic [HALF_W-1:0] w;
        w = '0;
        w[OF_BIT] = flag;
        w[INH_LSB +: 5] = inh;
        return w;
    endfunction

endpackage

// File: rtl/pmc_mode_filter.sv
module pmc_mode_filter
    import pmc_pkg::*;
(
    input  inh_t  inh,
    input  priv_t priv,
    input  logic  virt,
    output logic  block
);

    always_comb begin
        unique case (priv)
            PRIV_M:  block = inh.m;
            PRIV_S:  block = virt ? inh.vs : inh.s;
            PRIV_U:  block = virt ? inh.vu : inh.u;
            default: block = 1'b1;
        endcase
    end

endmodule

// File: rtl/pmc_slot.sv
module pmc_slot
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              glob_inh,
    input  priv_t             priv,
    input  logic              virt,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_ctl,
    input  logic [HALF_W-1:0] wdata,
    input  logic              ack,
    output logic [CNT_W-1:0]  count,
    output logic [HALF_W-1:0] ctl_rd,
    output logic              irq_req
);

    logic [HALF_W-1:0] lo_q, hi_q;
    inh_t              inh_q;
    ovf_state_t        st_q, st_d;
    logic              mode_block;
    logic              inc_ok, lo_full, wrap, flag;

    pmc_mode_filter u_filter (
        .inh   (inh_q),
        .priv  (priv),
        .virt  (virt),
        .block (mode_block)
    );

    assign lo_full = &lo_q;
    assign inc_ok  = evt && !wr_lo && !wr_hi && !glob_inh && !mode_block;
    assign wrap    = inc_ok && lo_full && (&hi_q);
    assign count   = {hi_q, lo_q};

    // count halves
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo) lo_q <= wdata;
            if (wr_hi) hi_q <= wdata;
            if (inc_ok) begin
                lo_q <= lo_q + 1'b1;
                if (lo_full) hi_q <= hi_q + 1'b1;
            end
        end
    end

    // inhibit bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inh_q <= '0;
        else if (wr_ctl) inh_q <= inh_t'(wdata[INH_LSB +: 5]);
    end

    // overflow state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OVF_CLEAR;
        else        st_q <= st_d;
    end

    // overflow next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OVF_CLEAR: begin
                if (wrap)                         st_d = OVF_PENDING;  // T_WRAP_NEW
                else if (wr_ctl && wdata[OF_BIT]) st_d = OVF_ACKED;    // T_SET_QUIET
            end
            OVF_PENDING: begin
                if (!wrap && wr_ctl && !wdata[OF_BIT]) st_d = OVF_CLEAR;  // T_SW_CLEAR
                else if (ack)                          st_d = OVF_ACKED;  // T_ACK
            end
            OVF_ACKED: begin
                if (!wrap && wr_ctl && !wdata[OF_BIT]) st_d = OVF_CLEAR;  // T_SW_CLEAR
            end
            default: st_d = OVF_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        flag    = (st_q != OVF_CLEAR);
        irq_req = (st_q == OVF_PENDING);
        ctl_rd  = ctl_pack(flag, inh_q);
    end

    AST_GLOBAL_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_inh && !wr_lo && !wr_hi) |=> $stable(count));  // R1
    AST_MODE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_block && !wr_lo && !wr_hi) |=> $stable(count));  // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));  // R4
    AST_NO_REPEAT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && flag) |=> !$rose(irq_req));  // R5
    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_ok && !lo_full) |=> (hi_q == $past(hi_q)));  // R6
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo_q == $past(wdata)));  // R9
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack) |=> !irq_req);  // R10
    AST_WRAP_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && wr_ctl) |=> flag);  // R11

endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int          NUM_IDX    = 32,
    parameter logic [31:0] AVAIL_MASK = 32'hFFFF_FFF8,
    localparam int         IDX_W      = $clog2(NUM_IDX),
    localparam int         ADDR_W     = IDX_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [ADDR_W-1:0]  csr_addr,
    input  logic [HALF_W-1:0]  csr_wdata,
    output logic [HALF_W-1:0]  csr_rdata,
    input  logic [NUM_IDX-1:0] evt_strobe,
    input  logic [1:0]         priv,
    input  logic               virt,
    input  logic               ovf_ack,
    input  logic [IDX_W-1:0]   ovf_ack_idx,
    output logic               ovf_irq
);

    logic [2:0]        sel;
    logic [IDX_W-1:0]  idx;
    logic [NUM_IDX-1:0] ginh_q;
    logic [NUM_IDX-1:0] irq_vec;
    logic [CNT_W-1:0]  cnt_arr [NUM_IDX];
    logic [HALF_W-1:0] ctl_arr [NUM_IDX];

    assign sel = csr_addr[ADDR_W-1 -: 3];
    assign idx = csr_addr[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ginh_q <= '0;
        else if (csr_we && sel == SEL_GINH) ginh_q <= csr_wdata[NUM_IDX-1:0];
    end

    for (genvar i = 0; i < NUM_IDX; i++) begin : g_idx
        if (i >= FIXED_N && AVAIL_MASK[i]) begin : g_slot
            logic hit;
            assign hit = csr_we && (idx == IDX_W'(i));
            pmc_slot u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt      (evt_strobe[i]),
                .glob_inh (ginh_q[i]),
                .priv     (priv_t'(priv)),
                .virt     (virt),
                .wr_lo    (hit && sel == SEL_CNT_LO),
                .wr_hi    (hit && sel == SEL_CNT_HI),
                .wr_ctl   (hit && sel == SEL_CTL),
                .wdata    (csr_wdata),
                .ack      (ovf_ack && ovf_ack_idx == IDX_W'(i)),
                .count    (cnt_arr[i]),
                .ctl_rd   (ctl_arr[i]),
                .irq_req  (irq_vec[i])
            );
        end else begin : g_none
            assign cnt_arr[i] = '0;
            assign ctl_arr[i] = '0;
            assign irq_vec[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CNT_LO: csr_rdata = cnt_arr[idx][HALF_W-1:0];
            SEL_CNT_HI: csr_rdata = cnt_arr[idx][CNT_W-1:HALF_W];
            SEL_CTL:    csr_rdata = ctl_arr[idx];
            SEL_GINH:   csr_rdata = HALF_W'(ginh_q);
            default:    csr_rdata = '0;
        endcase
    end

    assign ovf_irq = |irq_vec;

    AST_FIXED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CNT_LO && idx < IDX_W'(FIXED_N)) |-> (csr_rdata == '0));  // R8

endmodule

// File: tb/pmc_bank_test.sv
`timescale 1ns/10ps
module pmc_bank_test;

    localparam logic [31:0] MASK = 32'hFFFF_FFF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] evt = '0;
    logic [1:0]  priv = 2'b11;
    logic        virt = 1'b0;
    logic        ack = 1'b0;
    logic [4:0]  ack_idx = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [63:0] m_cnt [32];
    logic [4:0]  m_inh [32];
    int          m_st  [32];
    logic [31:0] m_ginh;

    always #2 clk = ~clk;

    pmc_bank uut (
        .clk(clk), .rst_n(rst_n), .csr_we(we), .csr_addr(addr), .csr_wdata(wdata),
        .csr_rdata(rdata), .evt_strobe(evt), .priv(priv), .virt(virt),
        .ovf_ack(ack), .ovf_ack_idx(ack_idx), .ovf_irq(irq)
    );

    function automatic bit f_avail(input int i);
        return (i >= 3) && MASK[i];
    endfunction

    // inh bits: [4]=m [3]=s [2]=u [1]=vs [0]=vu
    function automatic bit f_block(input logic [4:0] h, input logic [1:0] p, input logic v);
        case (p)
            2'b11:   return h[4];
            2'b01:   return v ? h[1] : h[3];
            2'b00:   return v ? h[0] : h[2];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] f_read(input logic [2:0] s, input int i);
        case (s)
            3'd0: return f_avail(i) ? m_cnt[i][31:0] : 32'd0;
            3'd1: return f_avail(i) ? m_cnt[i][63:32] : 32'd0;
            3'd2: return f_avail(i) ? {(m_st[i] != 0), m_inh[i], 26'd0} : 32'd0;
            3'd3: return m_ginh;
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit f_irq();
        for (int i = 0; i < 32; i++) if (m_st[i] == 1) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 32; i++) begin
            m_cnt[i] = '0; m_inh[i] = '0; m_st[i] = 0;
        end
        m_ginh = '0;
    endtask

    // apply one clock edge to the model using the inputs currently driven
    task automatic model_edge();
        logic [2:0] s;
        int ix;
        s = addr[7:5];
        ix = int'(addr[4:0]);
        for (int i = 0; i < 32; i++) begin
            if (f_avail(i)) begin
                bit wlo, whi, wct, inc, wrp, a;
                wlo = we && s == 3'd0 && ix == i;
                whi = we && s == 3'd1 && ix == i;
                wct = we && s == 3'd2 && ix == i;
                a   = ack && int'(ack_idx) == i;
                inc = evt[i] && !wlo && !whi && !m_ginh[i] && !f_block(m_inh[i], priv, virt);
                wrp = inc && (&m_cnt[i]);
                if (wlo) m_cnt[i][31:0] = wdata;
                if (whi) m_cnt[i][63:32] = wdata;
                if (inc) m_cnt[i] = m_cnt[i] + 64'd1;
                case (m_st[i])
                    0: if (wrp) m_st[i] = 1; else if (wct && wdata[31]) m_st[i] = 2;
                    1: if (!wrp && wct && !wdata[31]) m_st[i] = 0; else if (a) m_st[i] = 2;
                    default: if (!wrp && wct && !wdata[31]) m_st[i] = 0;
                endcase
                if (wct) m_inh[i] = wdata[30:26];
            end
        end
        if (we && s == 3'd3) m_ginh = wdata;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        we = 0; evt = '0; ack = 0;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] s, input int i);
        addr = {s, 5'(i)};
        #0.2;
        chk(tag, rdata, f_read(s, i));
    endtask

    task automatic irq_chk(input string tag);
        chk(tag, {31'd0, irq}, {31'd0, f_irq()});
    endtask

    task automatic csr_wr(input logic [2:0] s, input int i, input logic [31:0] d);
        we = 1; addr = {s, 5'(i)}; wdata = d;
        cyc();
        we = 0;
    endtask

    task automatic pulse(input int i, input int n);
        for (int k = 0; k < n; k++) begin
            evt = 32'd1 << i;
            cyc();
        end
        evt = '0;
    endtask

    task automatic sweep(input string tag);
        idle();
        for (int i = 0; i < 32; i++) begin
            rd_chk(tag, 3'd0, i);
            rd_chk(tag, 3'd1, i);
            rd_chk(tag, 3'd2, i);
        end
        rd_chk(tag, 3'd3, 0);
        irq_chk(tag);
    endtask

    initial begin
        #(4.0 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5171));
        model_reset();
        repeat (3) @(negedge clk);
        // R12 reset state
        rd_chk("R12 reset cnt", 3'd0, 3);
        rd_chk("R12 reset ctl", 3'd2, 31);
        rd_chk("R12 reset ginh", 3'd3, 0);
        irq_chk("R12 reset irq");
        rst_n = 1;
        @(negedge clk);

        // R1 basic counting in machine mode
        priv = 2'b11; virt = 0;
        pulse(3, 5);
        rd_chk("R1 count five", 3'd0, 3);
        // R1 shared inhibit register
        csr_wr(3'd3, 0, 32'h0000_0008);
        pulse(3, 4);
        rd_chk("R1 inhibited", 3'd0, 3);
        csr_wr(3'd3, 0, 32'h0);
        pulse(3, 1);
        rd_chk("R1 resumed", 3'd0, 3);

        // R2 supervisor filter, plain versus virtual
        csr_wr(3'd2, 4, 32'h2000_0000);  // s inhibit
        priv = 2'b01; virt = 0;
        pulse(4, 3);
        rd_chk("R2 s blocked", 3'd0, 4);
        virt = 1;
        pulse(4, 3);
        rd_chk("R2 vs counts", 3'd0, 4);
        csr_wr(3'd2, 4, 32'h0400_0000);  // vu inhibit
        priv = 2'b00; virt = 1;
        pulse(4, 2);
        rd_chk("R2 vu blocked", 3'd0, 4);
        virt = 0;
        pulse(4, 2);
        rd_chk("R2 u counts", 3'd0, 4);
        priv = 2'b10;
        pulse(4, 2);
        rd_chk("R2 reserved level", 3'd0, 4);

        // R3 machine mode ignores virt
        csr_wr(3'd2, 5, 32'h4000_0000);
        priv = 2'b11; virt = 1;
        pulse(5, 2);
        rd_chk("R3 m blocked virt", 3'd0, 5);
        csr_wr(3'd2, 5, 32'h0C00_0000);  // vs+vu only
        pulse(5, 3);
        rd_chk("R3 m counts virt", 3'd0, 5);
        virt = 0;

        // R6 carry into high half
        csr_wr(3'd0, 6, 32'hFFFF_FFFE);
        csr_wr(3'd1, 6, 32'h0000_0005);
        pulse(6, 1);
        rd_chk("R6 hi held", 3'd1, 6);
        pulse(6, 1);
        rd_chk("R6 lo wrapped", 3'd0, 6);
        rd_chk("R6 hi carried", 3'd1, 6);

        // R7 control layout
        csr_wr(3'd2, 7, 32'hFFFF_FFFF);
        rd_chk("R7 layout", 3'd2, 7);
        irq_chk("R7 quiet set");
        csr_wr(3'd2, 7, 32'h0);
        rd_chk("R7 cleared", 3'd2, 7);

        // R4 R5 wrap and interrupt
        csr_wr(3'd0, 8, 32'hFFFF_FFFF);
        csr_wr(3'd1, 8, 32'hFFFF_FFFF);
        pulse(8, 1);
        rd_chk("R4 wrap lo", 3'd0, 8);
        rd_chk("R4 wrap hi", 3'd1, 8);
        rd_chk("R5 flag set", 3'd2, 8);
        irq_chk("R5 irq raised");
        // R10 acknowledge
        ack = 1; ack_idx = 5'd8;
        cyc();
        ack = 0;
        irq_chk("R10 ack drops irq");
        // R5 second wrap while flag set
        csr_wr(3'd0, 8, 32'hFFFF_FFFF);
        csr_wr(3'd1, 8, 32'hFFFF_FFFF);
        pulse(8, 1);
        irq_chk("R5 no repeat irq");
        rd_chk("R5 flag still", 3'd2, 8);
        // R10 software clear
        csr_wr(3'd2, 8, 32'h0);
        rd_chk("R10 sw clear", 3'd2, 8);

        // R9 write beats event
        evt = 32'd1 << 3;
        csr_wr(3'd0, 3, 32'd100);
        evt = '0;
        rd_chk("R9 write wins", 3'd0, 3);

        // R11 wrap with control write clearing flag
        csr_wr(3'd0, 9, 32'hFFFF_FFFF);
        csr_wr(3'd1, 9, 32'hFFFF_FFFF);
        evt = 32'd1 << 9;
        csr_wr(3'd2, 9, 32'h0);
        evt = '0;
        rd_chk("R11 flag kept", 3'd2, 9);
        irq_chk("R11 irq up");

        // R8 fixed indices
        evt = 32'h0000_0007;
        csr_wr(3'd0, 1, 32'h1234_5678);
        pulse(0, 2);
        rd_chk("R8 idx1 lo", 3'd0, 1);
        rd_chk("R8 idx0 lo", 3'd0, 0);
        rd_chk("R8 idx2 ctl", 3'd2, 2);

        // R13 unused selectors
        csr_wr(3'd5, 3, 32'hFFFF_FFFF);
        rd_chk("R13 sel5 zero", 3'd5, 3);
        rd_chk("R13 untouched", 3'd0, 3);
        sweep("R13 directed sweep");

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = $urandom_range(0, 15);
            we = (r < 5);
            if (r < 2)       addr = {3'($urandom_range(0, 1)), 5'($urandom)};
            else if (r < 4)  addr = {3'd2, 5'($urandom)};
            else if (r == 4) addr = {3'($urandom_range(3, 7)), 5'($urandom)};
            if (r < 2 && $urandom_range(0, 1) == 1) wdata = 32'hFFFF_FFFF - $urandom_range(0, 3);
            else wdata = $urandom & $urandom;
            evt = $urandom;
            priv = 2'($urandom);
            virt = 1'($urandom);
            ack = ($urandom_range(0, 7) == 0);
            ack_idx = 5'($urandom);
            cyc();
            if (c % 200 == 199) sweep("R2 R5 R10 random sweep");
        end
        sweep("R4 R11 final sweep");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule